// File: doc/BRIEF.md
# Adaptive Overcurrent Acceptance Window

This block decides, for every switching cycle of a buck power stage, during which part of the high-side conduction interval an overcurrent comparator result is trusted. It counts how many clock ticks the high-side gate-on signal stays asserted. With a 100 MHz clock, one tick is 10 ns. When the switch turns off, the block stores three quarters of that count. In the next on-interval, a comparator trip is accepted only while the elapsed tick index is below the stored limit. A trip outside that window is ignored.

The comparator flag must already be synchronized to the block clock. A limit-enable input from the calibration logic turns fault reporting off when no usable trip level exists. The output is a registered, one-clock fault strobe. It fires at most once per on-interval and is meant to feed the restart and latch logic downstream.

Top module: `oc_window`

## Requirements
- R1: A fault strobe is produced only from a clock sample in which both `hsOn` and `ocTrip` are high. The strobe appears on `faultPulse` one clock after that sample. `ocTrip` while `hsOn` is low has no effect.
- R2: The on-time is the number of consecutive clock samples with `hsOn` high. The count saturates at 2^CNT_W-1 (255 with the default CNT_W=8) and does not wrap.
- R3: When `hsOn` falls, the window limit for the next on-interval becomes (n>>1)+(n>>2), where n is the measured on-time and each shift truncates. For example, n=3 gives 1 and n=255 gives 190.
- R4: Within an on-interval, samples are indexed 0, 1, 2 and so on from the first high sample. A trip at index k is accepted only if k is less than the limit stored at the end of the previous on-interval. A limit of 0 accepts nothing.
- R5: `faultPulse` is high for a single clock. At most one strobe is produced per on-interval, even if `ocTrip` stays high throughout.
- R6: After reset, no fault is produced until one on-interval has completed, meaning `hsOn` has risen and then fallen.
- R7: While `limitEn` is low, no trip is accepted.
- R8: During and right after reset, `faultPulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz block clock (10 ns tick) |
| rstN | input | 1 | Active-low asynchronous reset |
| hsOn | input | 1 | High-side gate-on, synchronous to clk |
| ocTrip | input | 1 | Synchronized overcurrent comparator flag |
| limitEn | input | 1 | Trip level valid from calibration; low disables faults |
| faultPulse | output | 1 | One-clock overcurrent fault strobe |

## Verification
Every internal state error in this block shows up only at `faultPulse`. A wrong on-time count or a wrong three-quarter limit moves the boundary tick where a trip stops being accepted. The error therefore appears only in the on-interval after the one that was mismeasured, and only when a trip arrives exactly at that boundary. For this reason, trips are placed one tick either side of the expected limit, for short, odd-length and saturated on-times. A stale "already fired" flag or a stale "reference present" flag shows up as a missing strobe or an extra strobe within one on-interval. A per-clock reference model catches this in the very clock it occurs.

// File: rtl/oc_window_pkg.sv
package oc_window_pkg;

  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic start;    // first high sample of an on-interval
    logic run;      // hsOn sampled high this clock
    logic capture;  // first low sample after an on-interval
  } winStrobe_t;

endpackage

// File: rtl/oc_window_dp.sv
module oc_window_dp
  import oc_window_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  winStrobe_t strobe,
  output logic       inWindow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] onCnt;
  logic [CNT_W-1:0] winLim;
  logic [CNT_W-1:0] tickIdx;
  logic [CNT_W-1:0] limNext;

  // Index of the current sample inside the on-interval.
  always_comb begin
    tickIdx = strobe.start ? '0 : onCnt;
  end

  // Three quarters with truncation of each shifted term.
  always_comb begin
    limNext = (onCnt >> 1) + (onCnt >> 2);
  end

  // On-time counter, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (strobe.start) begin
      onCnt <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (strobe.run && (onCnt != CNT_MAX)) begin
      onCnt <= onCnt + 1'b1;
    end
  end

  // Window limit captured at switch-off for use in the next interval.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winLim <= '0;
    end else if (strobe.capture) begin
      winLim <= limNext;
    end
  end

  always_comb begin
    inWindow = strobe.run && (tickIdx < winLim);
  end

  // R2: a saturated counter stays saturated while the switch is on
  a_r2_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.start && onCnt == CNT_MAX) |=> (onCnt == CNT_MAX));

  // R3: the stored limit never exceeds three quarters of the measured count
  a_r3_three_quarter: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ({2'b00, winLim} * 4) <= ({2'b00, $past(onCnt)} * 3));

  // R4: nothing lies inside the window while the switch is off
  a_r4_window_off: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> !inWindow);

endmodule

// File: rtl/oc_window_ctrl.sv
module oc_window_ctrl
  import oc_window_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsOn,
  input  logic       ocTrip,
  input  logic       limitEn,
  input  logic       inWindow,
  output winStrobe_t strobe,
  output logic       faultPulse
);

  logic hsOnQ;
  logic haveRef;
  logic fired;
  logic firedEff;
  logic hitNow;

  always_comb begin
    strobe.start   = hsOn && !hsOnQ;
    strobe.run     = hsOn;
    strobe.capture = !hsOn && hsOnQ;
  end

  // A new on-interval clears the per-interval fired flag.
  always_comb begin
    firedEff = fired && !strobe.start;
    hitNow   = hsOn && ocTrip && limitEn && haveRef && inWindow && !firedEff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsOnQ      <= 1'b0;
      haveRef    <= 1'b0;
      fired      <= 1'b0;
      faultPulse <= 1'b0;
    end else begin
      hsOnQ      <= hsOn;
      faultPulse <= hitNow;
      fired      <= firedEff || hitNow;
      if (strobe.capture) begin
        haveRef <= 1'b1;
      end
    end
  end

  // R1: each strobe stems from a sample with switch on and comparator tripped
  a_r1_source: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> ($past(hsOn) && $past(ocTrip)));

  // R5: strobe is one clock wide
  a_r5_single: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> !faultPulse);

  // R6: no strobe before a reference on-time exists
  a_r6_no_ref: assert property (@(posedge clk) disable iff (!rstN)
    !haveRef |=> !faultPulse);

  // R7: disabled limit suppresses the strobe
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !limitEn |=> !faultPulse);

endmodule

// File: rtl/oc_window.sv
module oc_window
  import oc_window_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic hsOn,
  input  logic ocTrip,
  input  logic limitEn,
  output logic faultPulse
);

  winStrobe_t strobe;
  logic       inWindow;

  oc_window_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hsOn       (hsOn),
    .ocTrip     (ocTrip),
    .limitEn    (limitEn),
    .inWindow   (inWindow),
    .strobe     (strobe),
    .faultPulse (faultPulse)
  );

  oc_window_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWindow (inWindow)
  );

  // R8: output quiet in the first clock after reset release
  a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !faultPulse);

endmodule

// File: tb/oc_window_tb.sv
module oc_window_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsOn = 1'b0;
  logic ocTrip = 1'b0;
  logic limitEn = 1'b0;
  logic faultPulse;

  int checks = 0;
  int failures = 0;
  int seen = 0;
  string phase = "R8";
  bit done = 1'b0;

  // behavioural model state
  int mCnt = 0;
  int mLim = 0;
  bit mRef = 0;
  bit mFired = 0;
  bit mPrev = 0;
  bit mExp = 0;

  always #5 clk = ~clk;

  oc_window u_dut (
    .clk(clk), .rstN(rstN), .hsOn(hsOn), .ocTrip(ocTrip),
    .limitEn(limitEn), .faultPulse(faultPulse)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mLim = 0; mRef = 0; mFired = 0; mPrev = 0; mExp = 0;
    end else begin
      bit hit;
      hit = 0;
      if (hsOn) begin
        int k;
        k = mPrev ? mCnt : 0;
        if (!mPrev) mFired = 0;
        hit = mRef && limitEn && ocTrip && (k < mLim) && !mFired;
        mCnt = mPrev ? ((mCnt < 255) ? mCnt + 1 : 255) : 1;
        if (hit) mFired = 1;
      end else if (mPrev) begin
        mLim = (mCnt >> 1) + (mCnt >> 2);
        mRef = 1;
      end
      mExp = hit;
      mPrev = hsOn;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (faultPulse !== mExp) begin
        failures++;
        $display("FAIL %s per-clock model: actual=%0b expected=%0b", phase, faultPulse, mExp);
      end
      if (faultPulse === 1'b1) seen++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s strobe count: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tripIdx: -1 none, -2 whole interval
  task automatic pulse(input int len, input int tripIdx, input bit en,
                       input int exp, input string tag);
    phase = tag;
    seen = 0;
    limitEn = en;
    for (int i = 0; i < len; i++) begin
      hsOn = 1'b1;
      ocTrip = (tripIdx == -2) || (i == tripIdx);
      @(negedge clk);
    end
    hsOn = 1'b0;
    ocTrip = 1'b0;
    repeat (4) @(negedge clk);
    check(tag, seen, exp);
  endtask

  initial begin
    #200000000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", int'(faultPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", int'(faultPulse), 0);

    // R6: first interval after reset, trip held high, no reference yet
    pulse(8, -2, 1'b1, 0, "R6");
    // R4: limit 6 -> index 5 accepted, index 6 rejected
    pulse(8, 5, 1'b1, 1, "R4");
    pulse(8, 6, 1'b1, 0, "R4");
    // R5: trip held for whole interval gives one strobe
    pulse(8, -2, 1'b1, 1, "R5");
    // R7: disabled limit
    pulse(8, -2, 1'b0, 0, "R7");
    // R1: trip while switch is off
    phase = "R1";
    seen = 0;
    limitEn = 1'b1;
    ocTrip = 1'b1;
    repeat (6) @(negedge clk);
    ocTrip = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", seen, 0);
    // R2: saturated count 255 -> limit 190
    pulse(300, -1, 1'b1, 0, "R2");
    pulse(300, 189, 1'b1, 1, "R2");
    pulse(300, 190, 1'b1, 0, "R2");
    // R3: n=3 -> limit 1 (truncated shifts)
    pulse(3, -1, 1'b1, 0, "R3");
    pulse(3, 1, 1'b1, 0, "R3");
    pulse(3, 0, 1'b1, 1, "R3");
    // R4: one-tick interval gives limit 0, nothing accepted
    pulse(1, -1, 1'b1, 0, "R4");
    pulse(4, 0, 1'b1, 0, "R4");
    // R1: strobe from a single-sample trip
    pulse(8, 2, 1'b1, 1, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule